// File: doc/BRIEF.md
# Decimator Settling-Suppression Sequencer

This block sets the output timing of a decimating wideband filter in the digital back end of a delta-sigma converter. It generates the decimated-rate strobe from the master clock and a selectable oversampling ratio. On every strobe the filter source presents one raw result, and the block forwards it to a held output word together with a one-cycle data-ready pulse.

Each restart resets the filter phase. A restart is a synchronization pulse, a change of the oversampling ratio, or the release of reset. After a restart the block hides results for a window made of a cycle overhead plus 68 decimated periods. The overhead is 16 cycles, or 24 with the input buffers on. While the window runs, the host never sees a word from a filter that has not settled. A status output is high for exactly that window. The filter arithmetic is not part of this block: the sample input stands in for it.

Top module: `settle_gate_seq`

## Requirements
- R1: `osr_sel_i` code k (0..7) selects an oversampling ratio of 32·2^k (32 to 4096). The decimated period P is 2·OSR master-clock cycles, and `rate_stb_o` is a one-cycle pulse once every P cycles.
- R2: Cycle 0 is the first cycle after the clock edge that sampled a restart. The lead overhead L takes cycles 0..L-1 and carries no strobe. The first strobe falls in cycle L+P-1 and later strobes follow every P cycles.
- R3: `sync_i` sampled high on an edge restarts the phase and the suppression window, and this also holds in the middle of a running window.
- R4: `settling_o` is high in cycles 0 to L+68·P-1 and low from cycle L+68·P. That window covers exactly 68 strobes, and `drdy_o` stays low throughout it.
- R5: L is 16 cycles when `buf_en_i` is low on the restart edge and 24 cycles when it is high. A change of `buf_en_i` between restarts has no effect.
- R6: A change of `osr_sel_i`, sampled on an edge, acts as a restart even with `sync_i` low.
- R7: Once the window has ended, each strobe in cycle t gives `drdy_o` high in cycle t+1 for one cycle, with `dout_o` holding the `smp_i` value from cycle t. The first pulse is in cycle L+69·P. `dout_o` holds its value between pulses.
- R8: While `rst_n` is low (synchronous), `drdy_o` and `rate_stb_o` are low and `settling_o` is high. Release of reset counts as a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osr_sel_i | input | 3 | Oversampling-ratio code |
| sync_i | input | 1 | Synchronization pulse, restarts the filter timing |
| buf_en_i | input | 1 | Input buffers enabled, lengthens the overhead |
| smp_i | input | SMP_W | Raw filter result, valid on the strobe cycle |
| rate_stb_o | output | 1 | Decimated-rate strobe |
| drdy_o | output | 1 | Data-ready pulse for a settled word |
| dout_o | output | SMP_W | Latched output word |
| settling_o | output | 1 | High while results are suppressed |

## Verification
The bench builds the block with a settling count of 6 periods and a minimum ratio exponent of 1, so the eight codes give periods of 4 to 512 cycles. With those values, every ratio code can be swept with the buffers both on and off in a few thousand cycles. Each run still covers all the window edges: lead overhead, first strobe, last suppressed strobe, first and second ready pulse. The overhead counts stay at their default values of 16 and 8, so the bench measures the cycle-exact overhead directly. Restarts in the middle of a window, by a new sync, by a ratio change and by reset, are measured on the same cycle grid.

// File: rtl/sgs_pkg.sv
// Shared types and helpers for the settling-suppression sequencer.
// Assumes ratio codes are 3 bits wide and map to successive powers of two.
package sgs_pkg;

    typedef logic [2:0] osr_code_t;

    localparam int unsigned OSR_CODE_COUNT = 8;

    // Decimated period in master-clock cycles for a ratio code.
    function automatic int unsigned period_clks(input osr_code_t code,
                                                input int unsigned min_log2);
        return 32'd1 << (min_log2 + 1 + int'(code));
    endfunction

endpackage

// File: rtl/sgs_restart.sv
// Restart detector: flags a restart on reset, a sync pulse or a change of
// the ratio code, and latches the ratio and the lead overhead on that edge.
// Assumes all inputs are synchronous to clk.
module sgs_restart
    import sgs_pkg::*;
#(
    parameter int unsigned BASE_OVH = 16,
    parameter int unsigned BUF_OVH  = 8,
    localparam int unsigned LEAD_W  = $clog2(BASE_OVH + BUF_OVH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  osr_code_t         osr_sel_i,
    input  logic              sync_i,
    input  logic              buf_en_i,
    output logic              restart_o,
    output osr_code_t         osr_cur_o,
    output logic [LEAD_W-1:0] lead_len_o
);

    osr_code_t         osr_q;
    logic [LEAD_W-1:0] lead_len_q;

    // Restart whenever reset, sync or a new ratio code is seen.
    always_comb restart_o = !rst_n || sync_i || (osr_sel_i != osr_q);

    // Track the active ratio code.
    always_ff @(posedge clk) osr_q <= osr_sel_i;

    // Latch the overhead length chosen by the buffer flag at each restart.
    always_ff @(posedge clk) begin
        if (restart_o)
            lead_len_q <= LEAD_W'(BASE_OVH) + (buf_en_i ? LEAD_W'(BUF_OVH) : LEAD_W'(0));
    end

    assign osr_cur_o  = osr_q;
    assign lead_len_o = lead_len_q;

    // R5: the latched overhead is one of the two legal values.
    p_lead_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_len_q == LEAD_W'(BASE_OVH)) || (lead_len_q == LEAD_W'(BASE_OVH + BUF_OVH)));

endmodule

// File: rtl/sgs_phase.sv
// Phase generator: holds through the lead overhead after a restart, then
// counts decimated periods and pulses the strobe on the last cycle of each.
// Assumes the period is at least two cycles.
module sgs_phase
    import sgs_pkg::*;
#(
    parameter int unsigned MIN_LOG2 = 5,
    parameter int unsigned LEAD_W   = 5,
    localparam int unsigned PH_W    = MIN_LOG2 + 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  osr_code_t         osr_code_i,
    input  logic [LEAD_W-1:0] lead_len_i,
    output logic              lead_o,
    output logic              stb_o
);

    logic [LEAD_W-1:0] lead_cnt;
    logic [PH_W-1:0]   ph_cnt;
    logic [PH_W-1:0]   ph_last;

    // Last phase index of the current period.
    always_comb ph_last = (PH_W'(1) << (PH_W'(MIN_LOG2 + 1) + PH_W'(osr_code_i))) - PH_W'(1);

    always_comb lead_o = (lead_cnt < lead_len_i);
    always_comb stb_o  = !lead_o && (ph_cnt == ph_last);

    // Count the lead overhead, then stop.
    always_ff @(posedge clk) begin
        if (restart_i)
            lead_cnt <= '0;
        else if (lead_o)
            lead_cnt <= lead_cnt + LEAD_W'(1);
    end

    // Advance the decimation phase once the lead is over.
    always_ff @(posedge clk) begin
        if (restart_i || lead_o)
            ph_cnt <= '0;
        else if (ph_cnt == ph_last)
            ph_cnt <= '0;
        else
            ph_cnt <= ph_cnt + PH_W'(1);
    end

    // R1: a strobe lasts one cycle.
    p_stb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);

    // R2: the phase counter never passes the period end.
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_cnt <= ph_last || restart_i || $past(restart_i));

endmodule

// File: rtl/sgs_settle.sv
// Settling tracker: counts strobes after a restart and keeps the settling
// flag up through the lead and the first SETTLE_PER strobes.
// Assumes strobes never appear while the lead is running.
module sgs_settle #(
    parameter int unsigned SETTLE_PER = 68,
    localparam int unsigned PER_W     = $clog2(SETTLE_PER + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic lead_i,
    input  logic stb_i,
    output logic settle_o
);

    logic [PER_W-1:0] per_cnt;
    logic             counting;

    always_comb counting = (per_cnt < PER_W'(SETTLE_PER));
    always_comb settle_o = lead_i || counting;

    // Count suppressed strobes until the window is full.
    always_ff @(posedge clk) begin
        if (restart_i)
            per_cnt <= '0;
        else if (stb_i && counting)
            per_cnt <= per_cnt + PER_W'(1);
    end

    // R4: the count never exceeds the window length.
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt <= PER_W'(SETTLE_PER));

    // R4: the window only ends on the cycle after a strobe.
    p_end_after_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(settle_o) |-> $past(stb_i));

endmodule

// File: rtl/sgs_outreg.sv
// Output stage: registers the sample and a one-cycle ready pulse for each
// strobe that falls outside the settling window.
// Assumes smp_i is valid in the strobe cycle.
module sgs_outreg #(
    parameter int unsigned SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             stb_i,
    input  logic             settle_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic             drdy_o,
    output logic [SMP_W-1:0] dout_o
);

    logic pass;

    always_comb pass = stb_i && !settle_i;

    // Ready pulse, cleared by any restart.
    always_ff @(posedge clk) begin
        if (restart_i)
            drdy_o <= 1'b0;
        else
            drdy_o <= pass;
    end

    // Hold the last settled word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_o <= '0;
        else if (pass && !restart_i)
            dout_o <= smp_i;
    end

    // R7: a ready pulse always follows a strobe outside the window.
    p_drdy_follows_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_o |-> $past(stb_i) && !$past(settle_i));

    // R7: the word only moves together with a ready pulse.
    p_dout_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_o |-> $stable(dout_o) || $past(!rst_n));

endmodule

// File: rtl/settle_gate_seq.sv
// Top level: decimated-rate timing with post-restart suppression of results.
// Assumes a single clock domain and a filter model that emits on each strobe.
module settle_gate_seq
    import sgs_pkg::*;
#(
    parameter int unsigned SMP_W      = 24,
    parameter int unsigned MIN_LOG2   = 5,
    parameter int unsigned SETTLE_PER = 68,
    parameter int unsigned BASE_OVH   = 16,
    parameter int unsigned BUF_OVH    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       osr_sel_i,
    input  logic             sync_i,
    input  logic             buf_en_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic             rate_stb_o,
    output logic             drdy_o,
    output logic [SMP_W-1:0] dout_o,
    output logic             settling_o
);

    localparam int unsigned LEAD_W = $clog2(BASE_OVH + BUF_OVH + 1);

    logic              restart;
    osr_code_t         osr_cur;
    logic [LEAD_W-1:0] lead_len;
    logic              lead;

    sgs_restart #(.BASE_OVH(BASE_OVH), .BUF_OVH(BUF_OVH)) restart_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .osr_sel_i  (osr_sel_i),
        .sync_i     (sync_i),
        .buf_en_i   (buf_en_i),
        .restart_o  (restart),
        .osr_cur_o  (osr_cur),
        .lead_len_o (lead_len)
    );

    sgs_phase #(.MIN_LOG2(MIN_LOG2), .LEAD_W(LEAD_W)) phase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .osr_code_i (osr_cur),
        .lead_len_i (lead_len),
        .lead_o     (lead),
        .stb_o      (rate_stb_o)
    );

    sgs_settle #(.SETTLE_PER(SETTLE_PER)) settle_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .lead_i    (lead),
        .stb_i     (rate_stb_o),
        .settle_o  (settling_o)
    );

    sgs_outreg #(.SMP_W(SMP_W)) outreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .stb_i     (rate_stb_o),
        .settle_i  (settling_o),
        .smp_i     (smp_i),
        .drdy_o    (drdy_o),
        .dout_o    (dout_o)
    );

    // R3: a sync pulse always reopens the window.
    p_sync_reopens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> settling_o && !drdy_o);

    // R6: a new ratio code reopens the window.
    p_osr_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (osr_sel_i != $past(osr_sel_i)) |=> settling_o);

    // R4: no ready pulse directly after a suppressed cycle.
    p_no_drdy_settling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        settling_o |=> !drdy_o);

endmodule

// File: tb/settle_gate_seq_tb_top.sv
// Sweep bench: every ratio code with buffers off and on, plus restarts in
// the middle of a window. Expected cycles come from L + k*P arithmetic.
module settle_gate_seq_tb_top;

    localparam int SMP_W  = 24;
    localparam int SETTLE = 6;
    localparam int MINL   = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       osr_sel_i = 3'd0;
    logic             sync_i = 1'b0;
    logic             buf_en_i = 1'b0;
    logic [SMP_W-1:0] smp_i = '0;
    logic             rate_stb_o;
    logic             drdy_o;
    logic [SMP_W-1:0] dout_o;
    logic             settling_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    settle_gate_seq #(
        .SMP_W(SMP_W), .MIN_LOG2(MINL), .SETTLE_PER(SETTLE),
        .BASE_OVH(16), .BUF_OVH(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .osr_sel_i(osr_sel_i), .sync_i(sync_i),
        .buf_en_i(buf_en_i), .smp_i(smp_i), .rate_stb_o(rate_stb_o),
        .drdy_o(drdy_o), .dout_o(dout_o), .settling_o(settling_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Measure one window; the current negedge is cycle 0.
    task automatic measure(input int code, input bit bufv, input string req);
        int p, lead, lim, settle_end, first_stb, nstb, d1, d2, dbad;
        logic [SMP_W-1:0] last_val, got1;
        p = 4 << code;
        lead = bufv ? 24 : 16;
        lim = lead + (SETTLE + 2) * p + 3;
        settle_end = -1; first_stb = -1; nstb = 0; d1 = -1; d2 = -1; dbad = 0;
        last_val = '0; got1 = '0;
        for (int t = 0; t < lim; t++) begin
            smp_i = SMP_W'(t * 37 + code * 1000 + 11);
            if (settle_end < 0 && !settling_o) settle_end = t;
            if (drdy_o) begin
                if (settle_end < 0) dbad++;
                else if (d1 < 0) begin d1 = t; got1 = dout_o; end
                else if (d2 < 0) d2 = t;
            end
            if (rate_stb_o) begin
                if (first_stb < 0) first_stb = t;
                if (settle_end < 0) nstb++;
                if (d1 < 0) last_val = smp_i;
            end
            @(negedge clk);
        end
        chk(settle_end == lead + SETTLE * p, {req, " R4 R5"}, "window length",
            settle_end, lead + SETTLE * p);
        chk(first_stb == lead + p - 1, {req, " R2"}, "first strobe", first_stb, lead + p - 1);
        chk(nstb == SETTLE, {req, " R4"}, "strobes in window", nstb, SETTLE);
        chk(dbad == 0, {req, " R4"}, "ready inside window", dbad, 0);
        chk(d1 == lead + (SETTLE + 1) * p, {req, " R7"}, "first ready", d1,
            lead + (SETTLE + 1) * p);
        chk(got1 == last_val, {req, " R7"}, "first word", got1, last_val);
        chk(d2 == d1 + p, {req, " R1"}, "ready spacing", d2 - d1, p);
    endtask

    task automatic sync_pulse();
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: state held during reset
        chk(drdy_o == 1'b0, "R8", "ready in reset", drdy_o, 0);
        chk(settling_o == 1'b1, "R8", "settling in reset", settling_o, 1);
        chk(rate_stb_o == 1'b0, "R8", "strobe in reset", rate_stb_o, 0);
        rst_n = 1'b1;
        measure(0, 1'b0, "R8 release");

        // R1 R5: sweep of every ratio code with buffers off and on
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 2; b++) begin
                osr_sel_i = 3'(c);
                buf_en_i = b[0];
                sync_pulse();
                measure(c, b[0], "R1 sweep");
            end
        end

        // R5: buffer change between restarts is ignored until the next one
        buf_en_i = 1'b0;
        osr_sel_i = 3'd1;
        sync_pulse();
        repeat (5) @(negedge clk);
        buf_en_i = 1'b1;
        repeat (100) @(negedge clk);
        sync_i = 1'b1; buf_en_i = 1'b0;
        @(negedge clk);
        sync_i = 1'b0; buf_en_i = 1'b1;
        measure(1, 1'b0, "R5 latch");

        // R3: a second sync inside the window restarts the count
        osr_sel_i = 3'd2;
        buf_en_i = 1'b0;
        sync_pulse();
        repeat (16 + 2 * 16) @(negedge clk);
        chk(settling_o == 1'b1, "R3", "still settling", settling_o, 1);
        sync_pulse();
        measure(2, 1'b0, "R3 resync");

        // R6: ratio change without sync inside a window
        osr_sel_i = 3'd3;
        sync_pulse();
        repeat (30) @(negedge clk);
        osr_sel_i = 3'd1;
        @(negedge clk);
        measure(1, 1'b0, "R6 ratio change");

        // R8: reset in the middle of a window
        osr_sel_i = 3'd2;
        sync_pulse();
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(drdy_o == 1'b0 && settling_o == 1'b1, "R8", "mid-window reset state",
            {drdy_o, settling_o}, 1);
        rst_n = 1'b1;
        measure(2, 1'b0, "R8 mid reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule